// File: doc/BRIEF.md
# Noise-Shaped Dual-Modulus Select Generator

This block drives the modulus control of a divider that can count either M or M+1 input pulses per output period. Once per reference clock it picks one of the two ratios, so that the long-run average ratio equals M + K/2^FW. K is a fraction word of FW bits. A first-order accumulator makes the choice. Each reference tick it adds K to a stored residue, and the carry out of the top bit requests the larger modulus.

With this scheme the larger-modulus periods are spread through the cycle as evenly as the word width allows. They are not grouped at one fixed removal rate. Quantization error therefore moves to high offset frequencies, and the periodic phase-error ramp that produces fixed spurs does not build up.

Each selection is registered. The block presents it as a single select bit and as the full divide value M or M+1. An enable input adds the low bit of a free-running shift register as an extra carry-in, which breaks up idle tones when the fraction is a simple ratio. With the enable low, the stream is fully deterministic.

Top module: `fracn_modulus_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, `mod_hi` is 0 and `div_val` is 0. The residue is cleared and the shift register is loaded with its seed.
- R2: After each tick, `div_val` equals the `m_int` value sampled at that tick plus `mod_hi` (1 = M+1 chosen, 0 = M chosen).
- R3: At every tick the FW-bit residue A and the fraction K form S = A + K + d, with d = 0 when dithering is off. `mod_hi` becomes bit FW of S, and A becomes S[FW-1:0].
- R4: Take any 2^FW consecutive ticks with K held constant and dithering off. Exactly K of those ticks select M+1.
- R5: With K = 0 and dithering off, every tick selects M.
- R6: A new K or M applies from the very next tick. The residue is not cleared when K or M changes.
- R7: When `dither_en` is 1 at a tick, d is bit 0 of the shift register. The register advances at every tick out of reset, whether or not dithering is on. Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}, and its seed is 16'hACE1.
- R8: The largest fraction K = 2^FW-1 with dithering off selects M on exactly one tick in every 2^FW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock; every rising edge is one tick |
| rst | input | 1 | Synchronous active-high reset |
| m_int | input | MW | Integer divide ratio M |
| k_frac | input | FW | Fraction word K, numerator over 2^FW |
| dither_en | input | 1 | Adds the shift-register bit as an extra carry-in |
| mod_hi | output | 1 | 1 when this period divides by M+1 |
| div_val | output | MW+1 | Divide value issued for this period, M or M+1 |

## Verification
The bench builds the block with MW = 6 and FW = 5. With these values one full residue cycle is 32 ticks, so the exact-count property can be checked across complete windows for many fractions, including 0, 1, 16 and the all-ones word. A 6-bit M reaches 63, so M+1 needs the extra output bit, and that carry is exercised. The short cycle also lets random changes of K land at many different residues, which tests the no-clear rule on K changes.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    // Which of the two ratios a reference period uses
    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } mod_sel_e;

    // Default shift-register shape for the dither source
    localparam int          DITH_W    = 16;
    localparam logic [15:0] DITH_TAPS = 16'hB400;
    localparam logic [15:0] DITH_SEED = 16'hACE1;

    function automatic mod_sel_e sel_from_carry(input logic c);
        return c ? SEL_HIGH : SEL_LOW;
    endfunction

endpackage

// File: rtl/sdm_dither_lfsr.sv
module sdm_dither_lfsr #(
    parameter int          LW   = 16,
    parameter logic [LW-1:0] TAPS = 16'hB400,
    parameter logic [LW-1:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    output logic bit_o
);
    logic [LW-1:0] state_q;
    logic          fb;

    assign fb    = ^(state_q & TAPS);
    assign bit_o = state_q[0];

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= {state_q[LW-2:0], fb};
    end
endmodule

// File: rtl/sdm_accum.sv
module sdm_accum #(
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] frac,
    input  logic          cin,
    output logic          carry
);
    logic [FW-1:0] resid_q;
    logic [FW:0]   sum;

    assign sum   = {1'b0, resid_q} + {1'b0, frac} + {{FW{1'b0}}, cin};
    assign carry = sum[FW];

    // Residue is kept across fraction changes for phase continuity
    always_ff @(posedge clk) begin
        if (rst) resid_q <= '0;
        else     resid_q <= sum[FW-1:0];
    end
endmodule

// File: rtl/sdm_mod_out.sv
module sdm_mod_out
    import sdm_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] m_int,
    input  mod_sel_e      sel,
    output logic          mod_hi,
    output logic [MW:0]   div_val
);
    localparam int DW = MW + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_hi  <= 1'b0;
            div_val <= '0;
        end else begin
            mod_hi  <= (sel == SEL_HIGH);
            div_val <= {1'b0, m_int} + DW'(sel == SEL_HIGH);
        end
    end
endmodule

// File: rtl/fracn_modulus_ctrl.sv
module fracn_modulus_ctrl
    import sdm_pkg::*;
#(
    parameter int MW          = 8,
    parameter int FW          = 12,
    parameter bit DITHER_IMPL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] m_int,
    input  logic [FW-1:0] k_frac,
    input  logic          dither_en,
    output logic          mod_hi,
    output logic [MW:0]   div_val
);
    logic     dith_bit;
    logic     cin;
    logic     carry;
    mod_sel_e sel;

    generate
        if (DITHER_IMPL) begin : g_dither
            sdm_dither_lfsr #(
                .LW  (DITH_W),
                .TAPS(DITH_TAPS),
                .SEED(DITH_SEED)
            ) u_lfsr (
                .clk  (clk),
                .rst  (rst),
                .bit_o(dith_bit)
            );
            assign cin = dither_en & dith_bit;
        end else begin : g_no_dither
            assign dith_bit = 1'b0;
            assign cin      = dith_bit & dither_en;
        end
    endgenerate

    sdm_accum #(.FW(FW)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .frac (k_frac),
        .cin  (cin),
        .carry(carry)
    );

    assign sel = sel_from_carry(carry);

    sdm_mod_out #(.MW(MW)) u_out (
        .clk    (clk),
        .rst    (rst),
        .m_int  (m_int),
        .sel    (sel),
        .mod_hi (mod_hi),
        .div_val(div_val)
    );
endmodule

// File: rtl/sdm_ctrl_checker.sv
module sdm_ctrl_checker #(
    parameter int MW = 8,
    parameter int FW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [MW-1:0] m_int,
    input logic [FW-1:0] k_frac,
    input logic          dither_en,
    input logic          mod_hi,
    input logic [MW:0]   div_val
);
    localparam int          CW  = FW + 1;
    localparam logic [CW-1:0] WIN = CW'(1) << FW;

    // Window tracker: each output sample is paired with the K that made it
    logic          seen, dq;
    logic [FW-1:0] kq, wk;
    logic [CW-1:0] wcnt, whi;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0; dq <= 1'b1; kq <= '0; wk <= '0;
            wcnt <= '0;   whi <= '0;
        end else begin
            seen <= 1'b1;
            kq   <= k_frac;
            dq   <= dither_en;
            if (!seen || dq) begin
                wcnt <= '0; whi <= '0; wk <= kq;
            end else if (kq != wk || wcnt == WIN) begin
                wk <= kq; wcnt <= CW'(1); whi <= CW'(mod_hi);
            end else begin
                wcnt <= wcnt + CW'(1); whi <= whi + CW'(mod_hi);
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!mod_hi && div_val == '0));                               // R1

    AST_DIV_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> div_val == ({1'b0, $past(m_int)} + (MW+1)'(mod_hi))); // R2

    AST_ZERO_FRAC_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(k_frac) == '0 && !$past(dither_en)) |-> !mod_hi); // R5

    AST_WINDOW_COUNT: assert property (@(posedge clk) disable iff (rst)
        (wcnt == WIN) |-> (whi == {1'b0, wk}));                             // R4

    AST_FULL_FRAC_GAP: assert property (@(posedge clk) disable iff (rst)
        (wcnt == WIN && wk == '1) |-> (whi == WIN - CW'(1)));               // R8
endmodule

bind fracn_modulus_ctrl sdm_ctrl_checker #(.MW(MW), .FW(FW)) u_sdm_chk (
    .clk      (clk),
    .rst      (rst),
    .m_int    (m_int),
    .k_frac   (k_frac),
    .dither_en(dither_en),
    .mod_hi   (mod_hi),
    .div_val  (div_val)
);

// File: tb/test_fracn_modulus_ctrl.sv
module test_fracn_modulus_ctrl;
    localparam int MW = 6;
    localparam int FW = 5;
    localparam int WIN = 1 << FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [MW-1:0] m_int = '0;
    logic [FW-1:0] k_frac = '0;
    logic          dither_en = 1'b0;
    logic          mod_hi;
    logic [MW:0]   div_val;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    logic [FW-1:0] acc_m;
    logic [15:0]   lfsr_m;
    logic          exp_hi;
    logic [MW:0]   exp_div;

    always #2 clk = ~clk;

    fracn_modulus_ctrl #(.MW(MW), .FW(FW)) i_fracn_modulus_ctrl (
        .clk(clk), .rst(rst), .m_int(m_int), .k_frac(k_frac),
        .dither_en(dither_en), .mod_hi(mod_hi), .div_val(div_val)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        acc_m = '0; lfsr_m = 16'hACE1; exp_hi = 1'b0; exp_div = '0;
        chk("R1 hi in reset", int'(mod_hi), 0);
        chk("R1 div in reset", int'(div_val), 0);
        rst = 1'b0;
    endtask

    // One tick: drive at negedge, model, check at next negedge
    task automatic tick(input logic [MW-1:0] m, input logic [FW-1:0] k,
                        input logic d, input string req);
        logic [FW:0] s;
        m_int = m; k_frac = k; dither_en = d;
        s = {1'b0, acc_m} + {1'b0, k} + {{FW{1'b0}}, (d & lfsr_m[0])};
        exp_hi  = s[FW];
        exp_div = {1'b0, m} + (MW+1)'(s[FW]);
        acc_m   = s[FW-1:0];
        lfsr_m  = lfsr_next(lfsr_m);
        @(negedge clk);
        chk(req, int'(mod_hi), int'(exp_hi));
        chk(req, int'(div_val), int'(exp_div));
    endtask

    task automatic window(input logic [MW-1:0] m, input logic [FW-1:0] k,
                          input int want, input string req);
        int cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            tick(m, k, 1'b0, req);
            cnt += int'(mod_hi);
        end
        chk(req, cnt, want);
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // First tick after reset release (R1 still zero before it)
        chk("R1 after reset", int'(mod_hi), 0);

        for (int i = 0; i < 40; i++) tick(6'd10, 5'd0, 1'b0, "R5 zero fraction");
        window(6'd12, 5'd1, 1, "R4 K=1 window");
        window(6'd12, 5'd16, 16, "R4 K=16 window");
        window(6'd12, 5'd11, 11, "R4 K=11 window");
        window(6'd63, 5'd31, 31, "R8 full fraction and M=63 carry");
        window(6'd0, 5'd7, 7, "R2 M=0 window");

        // Residue kept across K change (acc nonzero here)
        for (int i = 0; i < 5; i++) tick(6'd20, 5'd13, 1'b0, "R3 accumulate");
        tick(6'd21, 5'd29, 1'b0, "R6 change applies next tick");
        tick(6'd22, 5'd3, 1'b0, "R6 residue kept");

        // Dither exercised
        for (int i = 0; i < 40; i++) tick(6'd30, 5'd0, 1'b1, "R7 dither K=0");
        for (int i = 0; i < 20; i++) tick(6'd30, 5'd9, 1'b1, "R7 dither K=9");

        // Random segments
        for (int seg = 0; seg < 60; seg++) begin
            logic [MW-1:0] m = MW'($urandom);
            logic [FW-1:0] k = FW'($urandom);
            logic d = ($urandom % 4) == 0;
            int len = 1 + ($urandom % 40);
            for (int i = 0; i < len; i++) tick(m, k, d, "R3 random");
        end

        // Reset in mid-run then resume
        do_reset();
        chk("R1 after second reset", int'(div_val), 0);
        window(6'd5, 5'd21, 21, "R4 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (cycles < 150000 && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule